// File: doc/BRIEF.md
# Vector Configuration and Length Controller

This block holds the configuration and active vector length of a vector unit. Software builds a configuration in steps: each step names one element width (as a base-2 logarithm of its bit count) and how many registers of that width it wants. The steps are only summed and remembered; the register budget is checked at the next length-set operation. When that check passes, the unit becomes configured, the register file is told to clear itself, and the granted length is computed as the smaller of the requested length and the most elements of the widest configured width that fit in one register.

Length-set operations also carry a family of zero-operand control operations, selected by the source register index when the destination index is zero: clear pending modifiers, unconfigure (power off), reset (on but blank), and four synchronization flavours that never fault. Decoded operations arrive with their register indices and the first source value; all results appear one clock after the operation is sampled.

Top module: `vcfg_len_ctrl`

## Requirements
- R1: After reset, state is 2'b00 (off), the length is 0 and wr_en, exc, clr_regs and mods_clr are all low.
- R2: A configuration step (op_kind 2'b01) takes rd_idx as log2 of the element width, legal from 3 to 6, and rs1_idx as the register count, where 0 stands for 32. A legal step moves the unit from off (2'b00), idle (2'b01) or pending (2'b10) to pending; an illegal width raises exc and changes nothing.
- R3: A length-set or get-length (op_kind 2'b10, rd_idx not 0) while pending validates the summed count: at most 32 makes the unit configured (2'b11) with a one-cycle clr_regs pulse and a length of 0 before the operation itself applies; more than 32 raises exc, writes nothing and returns the unit to idle with the steps discarded.
- R4: While configured, a length-set with rs1_idx not 0 sets the length to min(rs1_val, 512 >> widest log2 width) and writes it back with wr_en.
- R5: While configured, a length-set with rs1_idx 0 (get-length) leaves the length unchanged and writes the current length back.
- R6: Control code 0 (rd_idx 0, rs1_idx 0) while configured only pulses mods_clr: no write, no length or state change.
- R7: A configuration step while configured raises exc and leaves state and length unchanged.
- R8: Control code 1 (unconfigure) moves the unit to off from any state and sets the length to 0.
- R9: Control code 2 (reset) moves the unit to idle from any state, including off, and sets the length to 0.
- R10: Control codes 3 to 6 (synchronization) never raise exc and never change state or length, including while off.
- R11: A plain vector operation (op_kind 2'b00 or 2'b11), control code 0, control codes 7 and above, and a length-set or get-length while off or idle all raise exc.
- R12: mods_clr pulses for every length-set-family operation that raises no exception and never together with exc; an exception never comes with a write or clr_regs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A decoded operation is present this cycle |
| op_kind | input | 2 | 00 vector op, 01 configuration step, 10 length-set family, 11 vector op |
| rd_idx | input | 5 | Destination index (width log2 for a step) |
| rs1_idx | input | 5 | Source index (count for a step, control code when rd_idx is 0) |
| rs1_val | input | XLEN | Value of the source register (requested length) |
| wr_en | output | 1 | Destination write strobe |
| wr_data | output | XLEN | Value for the destination register |
| exc | output | 1 | Exception pulse |
| clr_regs | output | 1 | Clear-all-vector-registers pulse |
| mods_clr | output | 1 | Discard-pending-modifiers pulse |
| vl | output | XLEN | Current vector length |
| state | output | 2 | 00 off, 01 idle, 10 pending, 11 configured |

## Verification
On every cycle the assertions check that an exception never travels with a write, a clear or a modifier pulse, that any written value equals the new length, that the length is zero outside the configured state, and that register clearing only follows a pending-to-configured move; they also pin the state after reset, unconfigure, sync and a rejected step. Whether the granted length is the right minimum, whether the register budget is summed correctly with the zero-means-32 rule, and whether the widest width governs the maximum can only be shown by the bench's scenarios against its reference model.

// File: rtl/vcl_pkg.sv
// Shared types for the vector configuration and length controller.
// Assumes the decoder upstream supplies an operation kind and raw indices.
package vcl_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_IDLE = 2'b01,
        ST_PEND = 2'b10,
        ST_CONF = 2'b11
    } vcl_state_e;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_VEC,
        CMD_STEP,
        CMD_SETVL,
        CMD_GETVL,
        CMD_CLRMOD,
        CMD_UNCFG,
        CMD_RESET,
        CMD_SYNC,
        CMD_RSVD
    } vcl_cmd_e;

    localparam logic [1:0] KIND_STEP  = 2'b01;
    localparam logic [1:0] KIND_SETVL = 2'b10;

    localparam logic [4:0] CODE_CLRMOD   = 5'd0;
    localparam logic [4:0] CODE_UNCFG    = 5'd1;
    localparam logic [4:0] CODE_RESET    = 5'd2;
    localparam logic [4:0] CODE_SYNC_LO  = 5'd3;
    localparam logic [4:0] CODE_SYNC_HI  = 5'd6;

endpackage

// File: rtl/vcl_decode.sv
// Operation classifier: turns kind plus register indices into one command.
// Purely combinational; assumes indices are valid whenever op_valid is high.
module vcl_decode
    import vcl_pkg::*;
(
    input  logic       op_valid,
    input  logic [1:0] op_kind,
    input  logic [4:0] rd_idx,
    input  logic [4:0] rs1_idx,
    output vcl_cmd_e   cmd
);

    // Classify the incoming operation.
    always_comb begin
        cmd = CMD_NONE;
        if (op_valid) begin
            if (op_kind == KIND_STEP) begin
                cmd = CMD_STEP;
            end else if (op_kind == KIND_SETVL) begin
                if (rd_idx != 5'd0) begin
                    cmd = (rs1_idx == 5'd0) ? CMD_GETVL : CMD_SETVL;
                end else if (rs1_idx == CODE_CLRMOD) begin
                    cmd = CMD_CLRMOD;
                end else if (rs1_idx == CODE_UNCFG) begin
                    cmd = CMD_UNCFG;
                end else if (rs1_idx == CODE_RESET) begin
                    cmd = CMD_RESET;
                end else if (rs1_idx >= CODE_SYNC_LO && rs1_idx <= CODE_SYNC_HI) begin
                    cmd = CMD_SYNC;
                end else begin
                    cmd = CMD_RSVD;
                end
            end else begin
                cmd = CMD_VEC;
            end
        end
    end

endmodule

// File: rtl/vcl_step_accum.sv
// Configuration step accumulator: sums requested register counts (saturating)
// and remembers the widest element width seen. Assumes add and clear are
// never both high; clear wins if they are.
module vcl_step_accum #(
    parameter int LG_MIN = 3,
    parameter int LG_MAX = 6,
    parameter int CNT_W  = 6,
    parameter int TOT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add,
    input  logic [4:0]       lg_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             lg_ok,
    output logic [TOT_W-1:0] total,
    output logic [4:0]       widest
);

    localparam logic [TOT_W:0] SAT = {1'b0, {TOT_W{1'b1}}};

    logic [TOT_W:0] sum;

    // Legal width range check for the incoming step.
    always_comb begin
        lg_ok = (lg_in >= 5'(LG_MIN)) && (lg_in <= 5'(LG_MAX));
        sum   = {1'b0, total} + (TOT_W+1)'(cnt_in);
    end

    // Running total and widest width registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            total  <= '0;
            widest <= 5'(LG_MIN);
        end else if (add) begin
            total <= (sum > SAT) ? SAT[TOT_W-1:0] : sum[TOT_W-1:0];
            if (lg_in > widest) begin
                widest <= lg_in;
            end
        end
    end

endmodule

// File: rtl/vcl_len_calc.sv
// Granted-length calculator: maximum elements per register for the widest
// width, and the minimum of that and the requested length. Combinational.
module vcl_len_calc #(
    parameter int XLEN      = 32,
    parameter int VREG_BITS = 512
) (
    input  logic [4:0]      widest,
    input  logic [XLEN-1:0] req,
    output logic [XLEN-1:0] maxvl,
    output logic [XLEN-1:0] granted
);

    // Shift the register size by the width log and clamp the request.
    always_comb begin
        maxvl   = XLEN'(VREG_BITS) >> widest;
        granted = (req < maxvl) ? req : maxvl;
    end

endmodule

// File: rtl/vcfg_len_ctrl.sv
// Vector configuration and length controller (top).
// Tracks off / idle / pending / configured, accepts configuration steps,
// validates them at the next length-set, grants lengths and executes the
// zero-operand control codes. All outputs are registered, one clock after
// the operation is sampled. Assumes one operation per cycle at most.
module vcfg_len_ctrl
    import vcl_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int VREG_BITS = 512,
    parameter int NREGS     = 32,
    parameter int LG_MIN    = 3,
    parameter int LG_MAX    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic [4:0]      rd_idx,
    input  logic [4:0]      rs1_idx,
    input  logic [XLEN-1:0] rs1_val,
    output logic            wr_en,
    output logic [XLEN-1:0] wr_data,
    output logic            exc,
    output logic            clr_regs,
    output logic            mods_clr,
    output logic [XLEN-1:0] vl,
    output logic [1:0]      state
);

    localparam int CNT_W = $clog2(NREGS) + 1;
    localparam int TOT_W = $clog2(NREGS) + 3;

    vcl_state_e       st_q;
    vcl_cmd_e         cmd;
    logic [CNT_W-1:0] step_cnt;
    logic             lg_ok;
    logic [TOT_W-1:0] total;
    logic [4:0]       widest;
    logic [XLEN-1:0]  maxvl;
    logic [XLEN-1:0]  granted;
    logic             budget_ok;
    logic             step_take;
    logic             acc_clear;

    vcl_decode u_dec (
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .rd_idx   (rd_idx),
        .rs1_idx  (rs1_idx),
        .cmd      (cmd)
    );

    // Step count with the zero-means-full-file rule, and accumulator controls.
    always_comb begin
        step_cnt  = (rs1_idx == 5'd0) ? CNT_W'(NREGS) : CNT_W'(rs1_idx);
        budget_ok = (total <= TOT_W'(NREGS));
        step_take = (cmd == CMD_STEP) && (st_q != ST_CONF) && lg_ok;
        acc_clear = (cmd == CMD_UNCFG) || (cmd == CMD_RESET) ||
                    (((cmd == CMD_SETVL) || (cmd == CMD_GETVL)) &&
                     (st_q == ST_PEND) && !budget_ok);
    end

    vcl_step_accum #(
        .LG_MIN (LG_MIN),
        .LG_MAX (LG_MAX),
        .CNT_W  (CNT_W),
        .TOT_W  (TOT_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (acc_clear),
        .add    (step_take),
        .lg_in  (rd_idx),
        .cnt_in (step_cnt),
        .lg_ok  (lg_ok),
        .total  (total),
        .widest (widest)
    );

    vcl_len_calc #(
        .XLEN      (XLEN),
        .VREG_BITS (VREG_BITS)
    ) u_len (
        .widest  (widest),
        .req     (rs1_val),
        .maxvl   (maxvl),
        .granted (granted)
    );

    // State machine, length register and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_OFF;
            vl       <= '0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
            exc      <= 1'b0;
            clr_regs <= 1'b0;
            mods_clr <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            exc      <= 1'b0;
            clr_regs <= 1'b0;
            mods_clr <= 1'b0;
            unique case (cmd)
                CMD_NONE: ;
                CMD_VEC: begin
                    if (st_q != ST_CONF) exc <= 1'b1;
                end
                CMD_STEP: begin
                    if (step_take) st_q <= ST_PEND;
                    else           exc  <= 1'b1;
                end
                CMD_SETVL, CMD_GETVL: begin
                    if (st_q == ST_CONF || (st_q == ST_PEND && budget_ok)) begin
                        st_q     <= ST_CONF;
                        wr_en    <= 1'b1;
                        mods_clr <= 1'b1;
                        if (st_q == ST_PEND) clr_regs <= 1'b1;
                        if (cmd == CMD_SETVL) begin
                            vl      <= granted;
                            wr_data <= granted;
                        end else if (st_q == ST_PEND) begin
                            vl      <= '0;
                            wr_data <= '0;
                        end else begin
                            wr_data <= vl;
                        end
                    end else begin
                        exc <= 1'b1;
                        if (st_q == ST_PEND) st_q <= ST_IDLE;
                    end
                end
                CMD_CLRMOD: begin
                    if (st_q == ST_CONF) mods_clr <= 1'b1;
                    else                 exc      <= 1'b1;
                end
                CMD_UNCFG: begin
                    st_q     <= ST_OFF;
                    vl       <= '0;
                    mods_clr <= 1'b1;
                end
                CMD_RESET: begin
                    st_q     <= ST_IDLE;
                    vl       <= '0;
                    mods_clr <= 1'b1;
                end
                CMD_SYNC: begin
                    mods_clr <= 1'b1;
                end
                default: begin
                    exc <= 1'b1;
                end
            endcase
        end
    end

    assign state = st_q;

endmodule

// File: rtl/vcl_checker.sv
// Property checker for vcfg_len_ctrl, attached with bind below.
module vcl_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op_kind,
    input logic [4:0]      rd_idx,
    input logic [4:0]      rs1_idx,
    input logic            wr_en,
    input logic [XLEN-1:0] wr_data,
    input logic            exc,
    input logic            clr_regs,
    input logic            mods_clr,
    input logic [XLEN-1:0] vl,
    input logic [1:0]      state
);

    logic is_ctl;
    assign is_ctl = op_valid && (op_kind == 2'b10) && (rd_idx == 5'd0);

    AST_EXC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (!wr_en && !clr_regs && !mods_clr)); // R12

    AST_WRITE_IS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == vl)); // R4

    AST_ZERO_LEN_UNCONF: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'b11) |-> (vl == '0)); // R8

    AST_CLEAR_ON_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_regs |-> ((state == 2'b11) && ($past(state) == 2'b10))); // R3

    AST_STEP_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01 && state == 2'b11) |=> (exc && state == 2'b11)); // R7

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && rs1_idx >= 5'd3 && rs1_idx <= 5'd6) |=>
        (!exc && state == $past(state) && vl == $past(vl))); // R10

    AST_RESET_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && rs1_idx == 5'd2) |=> (state == 2'b01 && vl == '0)); // R9

    AST_UNCFG_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && rs1_idx == 5'd1) |=> (state == 2'b00)); // R8

endmodule

bind vcfg_len_ctrl vcl_checker #(.XLEN(XLEN)) u_vcl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .rd_idx   (rd_idx),
    .rs1_idx  (rs1_idx),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .exc      (exc),
    .clr_regs (clr_regs),
    .mods_clr (mods_clr),
    .vl       (vl),
    .state    (state)
);

// File: tb/tb_vcfg_len_ctrl.sv
// Bench: behavioural reference model compared on every clock, plus
// directed literal checks after key operations.
module tb_vcfg_len_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [4:0]  rd_idx = 5'd0;
    logic [4:0]  rs1_idx = 5'd0;
    logic [31:0] rs1_val = 32'd0;
    logic        wr_en, exc, clr_regs, mods_clr;
    logic [31:0] wr_data, vl;
    logic [1:0]  state;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string tag = "R1";

    // Reference model state
    int m_st = 0, m_tot = 0, m_wid = 3;
    longint m_vl = 0, e_wd = 0;
    bit e_wr = 0, e_exc = 0, e_clr = 0, e_mc = 0;
    bit model_live = 0;

    vcfg_len_ctrl dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs1_val(rs1_val),
        .wr_en(wr_en), .wr_data(wr_data), .exc(exc), .clr_regs(clr_regs),
        .mods_clr(mods_clr), .vl(vl), .state(state)
    );

    always #2 clk = ~clk;

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        longint mx;
        model_live = 1;
        if (!rst_n) begin
            m_st = 0; m_tot = 0; m_wid = 3; m_vl = 0;
            e_wr = 0; e_exc = 0; e_clr = 0; e_mc = 0;
        end else begin
            e_wr = 0; e_exc = 0; e_clr = 0; e_mc = 0;
            if (op_valid) begin
                if (op_kind == 2'b01) begin
                    if (m_st == 3 || rd_idx < 3 || rd_idx > 6) e_exc = 1;
                    else begin
                        m_st = 2;
                        m_tot += (rs1_idx == 0) ? 32 : int'(rs1_idx);
                        if (int'(rd_idx) > m_wid) m_wid = rd_idx;
                    end
                end else if (op_kind == 2'b10 && rd_idx != 0) begin
                    if (m_st == 2) begin
                        if (m_tot <= 32) begin m_st = 3; e_clr = 1; m_vl = 0; end
                        else begin e_exc = 1; m_st = 1; m_tot = 0; m_wid = 3; end
                    end else if (m_st != 3) e_exc = 1;
                    if (m_st == 3 && !e_exc) begin
                        if (rs1_idx != 0) begin
                            mx = 512 >> m_wid;
                            m_vl = (longint'(rs1_val) < mx) ? longint'(rs1_val) : mx;
                        end
                        e_wr = 1; e_wd = m_vl; e_mc = 1;
                    end
                end else if (op_kind == 2'b10) begin
                    case (rs1_idx)
                        0: if (m_st == 3) e_mc = 1; else e_exc = 1;
                        1: begin m_st = 0; m_tot = 0; m_wid = 3; m_vl = 0; e_mc = 1; end
                        2: begin m_st = 1; m_tot = 0; m_wid = 3; m_vl = 0; e_mc = 1; end
                        3, 4, 5, 6: e_mc = 1;
                        default: e_exc = 1;
                    endcase
                end else begin
                    if (m_st != 3) e_exc = 1;
                end
            end
        end
    end

    task automatic check(string req, longint act, longint exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (model_live && !finished) begin
            check(tag, exc, e_exc, "exc");
            check(tag, wr_en, e_wr, "wr_en");
            check(tag, clr_regs, e_clr, "clr_regs");
            check(tag, mods_clr, e_mc, "mods_clr");
            check(tag, vl, m_vl, "vl");
            check(tag, state, m_st, "state");
            if (e_wr) check(tag, wr_data, e_wd, "wr_data");
        end
    end

    task automatic issue(string t, logic [1:0] k, logic [4:0] rd, logic [4:0] rs, logic [31:0] v);
        @(negedge clk);
        tag = t; op_valid = 1; op_kind = k; rd_idx = rd; rs1_idx = rs; rs1_val = v;
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", state, 0, "reset state"); check("R1", vl, 0, "reset vl");
        check("R1", exc | wr_en | clr_regs | mods_clr, 0, "reset pulses");

        issue("R11", 2'b00, 5'd1, 5'd2, 0); check("R11", exc, 1, "vec op off");
        issue("R10", 2'b10, 5'd0, 5'd4, 0); check("R10", exc, 0, "sync off");
        check("R10", state, 0, "sync off state");
        issue("R2", 2'b01, 5'd2, 5'd4, 0); check("R2", exc, 1, "bad width");
        issue("R2", 2'b01, 5'd7, 5'd4, 0); check("R2", state, 0, "bad width state");
        issue("R2", 2'b01, 5'd5, 5'd8, 0); check("R2", state, 2, "step pending");
        issue("R2", 2'b01, 5'd4, 5'd0, 0);
        issue("R3", 2'b10, 5'd1, 5'd1, 10); check("R3", exc, 1, "over budget 40");
        check("R3", state, 1, "back to idle");
        issue("R11", 2'b10, 5'd0, 5'd0, 0); check("R11", exc, 1, "clrmod idle");
        issue("R11", 2'b10, 5'd3, 5'd0, 0); check("R11", exc, 1, "getvl idle");

        issue("R2", 2'b01, 5'd4, 5'd16, 0);
        issue("R2", 2'b01, 5'd5, 5'd8, 0);
        issue("R3", 2'b10, 5'd1, 5'd1, 100); check("R3", clr_regs, 1, "clear pulse");
        check("R4", vl, 16, "grant clamp widest 32b");
        issue("R4", 2'b10, 5'd2, 5'd3, 7); check("R4", wr_data, 7, "grant 7");
        issue("R5", 2'b10, 5'd2, 5'd0, 999); check("R5", wr_data, 7, "getvl");
        check("R5", vl, 7, "getvl keeps vl");
        issue("R6", 2'b10, 5'd0, 5'd0, 0); check("R6", mods_clr, 1, "clrmod");
        check("R6", wr_en, 0, "clrmod no write");
        issue("R7", 2'b01, 5'd3, 5'd1, 0); check("R7", exc, 1, "step when conf");
        check("R7", vl, 7, "step when conf vl");
        issue("R11", 2'b11, 5'd1, 5'd1, 0); check("R11", exc, 0, "vec op conf");
        issue("R11", 2'b10, 5'd0, 5'd9, 0); check("R11", exc, 1, "reserved code");
        issue("R10", 2'b10, 5'd0, 5'd6, 0); check("R10", vl, 7, "sync conf");
        issue("R12", 2'b10, 5'd0, 5'd3, 0); check("R12", mods_clr, 1, "sync mods");

        issue("R9", 2'b10, 5'd0, 5'd2, 0); check("R9", state, 1, "reset idle");
        issue("R2", 2'b01, 5'd3, 5'd0, 0);
        issue("R3", 2'b10, 5'd4, 5'd0, 0); check("R3", state, 3, "exact 32 ok");
        check("R3", wr_data, 0, "getvl at completion");
        issue("R4", 2'b10, 5'd4, 5'd5, 1000); check("R4", vl, 64, "clamp 8b");
        issue("R4", 2'b10, 5'd4, 5'd5, 64); check("R4", vl, 64, "exact max");
        issue("R4", 2'b10, 5'd4, 5'd5, 0); check("R4", vl, 0, "zero request");
        issue("R4", 2'b10, 5'd4, 5'd5, 63); check("R4", vl, 63, "below max");

        issue("R8", 2'b10, 5'd0, 5'd1, 0); check("R8", state, 0, "uncfg off");
        check("R8", vl, 0, "uncfg vl");
        issue("R9", 2'b10, 5'd0, 5'd2, 0); check("R9", state, 1, "reset from off");
        issue("R2", 2'b01, 5'd6, 5'd2, 0);
        issue("R3", 2'b10, 5'd1, 5'd1, 5); check("R4", vl, 5, "wide grant");
        issue("R12", 2'b10, 5'd1, 5'd1, 9); check("R12", vl, 8, "clamp 64b");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule